// File: doc/BRIEF.md
# Dual-Level Exception Entry Unit

This block performs the architectural state change that a RISC core makes when it accepts one of two interrupt levels: a fast level and a normal level. Each level has a request input. The requests are resynchronised to the core clock and then gated by two disable bits in the 32-bit current status word. When a level is accepted, the unit takes the following actions. It banks the status word into a saved copy that belongs to that level. It stores a return link equal to the next-instruction address plus 4. It rewrites the mode field and the state and disable bits. It loads the program counter with the level's vector, which comes from either a low or a high vector base.

A return strobe undoes the entry of the level that is active at that moment. It reloads the program counter from that level's link minus 4 and restores the status word from that level's saved copy. The core may also write the status word directly, for example to unmask interrupts. Instruction fetch and execution are outside this unit. The unit only produces the new PC, with a one-cycle load pulse, and the new status word.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, statusOut equals the parameter RESET_STATUS (default 0x000000D3), pcOut is 0, pcLoad is 0, and all link and saved-status registers are 0.
- R2: Each request input passes through two synchronising flops. A request that is held high before rising edge 1 causes an entry that is visible at the outputs after rising edge 3, and not earlier.
- R3: Status bit 6 set blocks the fast request, and status bit 7 set blocks the normal request. A blocked request changes no output.
- R4: When both synchronised requests are pending and both are enabled, only the fast level is taken. The normal request stays blocked for as long as bit 7 remains set afterwards.
- R5: On entry, the saved-status register of the level taken receives the status word as it was before entry, and that level's link register receives nextPc + 4. The other level's registers are unchanged.
- R6: On entry, status bits [4:0] become 5'b10001 for fast and 5'b10010 for normal. Bit 5 is cleared and bit 7 is set. Bit 6 is set on a fast entry and keeps its value on a normal entry. Bits [31:8] are unchanged.
- R7: The vector loaded into pcOut is 0x0000001C for fast and 0x00000018 for normal when highVec is 0. When highVec is 1, it is 0xFFFF001C for fast and 0xFFFF0018 for normal.
- R8: With retReq high, the action depends on the current mode. In mode 5'b10001, pcOut becomes linkFast - 4 and the status word becomes savedFast. In mode 5'b10010, the normal-level pair is used in the same way. In any other mode, retReq changes nothing.
- R9: In a single cycle, an entry wins over a return and over a status write, and a return wins over a status write. The losing operations have no effect.
- R10: pcLoad is high for exactly the one cycle that follows an entry or a performed return, and is low at all other times.
- R11: With statusWrEn high and no entry or return in that cycle, the status word takes statusWrData on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fastReq | input | 1 | Fast-level request, asynchronous, level sensitive |
| normReq | input | 1 | Normal-level request, asynchronous, level sensitive |
| highVec | input | 1 | Selects the high vector base |
| nextPc | input | 32 | Address of the next instruction to execute |
| retReq | input | 1 | Return-from-handler strobe |
| statusWrEn | input | 1 | Direct status-word write enable |
| statusWrData | input | 32 | Value for the direct status write |
| statusOut | output | 32 | Current status word |
| pcOut | output | 32 | Last loaded program counter |
| pcLoad | output | 1 | Pulse: pcOut has just been loaded |
| linkFast | output | 32 | Fast-level return link |
| linkNorm | output | 32 | Normal-level return link |
| savedFast | output | 32 | Fast-level saved status |
| savedNorm | output | 32 | Normal-level saved status |

## Verification
The unit is first driven with requests while the matching disable bit is set. This shows that gating acts on each level separately. A normal entry taken from a status word with bit 5 and bit 6 set apart shows the clear-state rule and the keep-fast-disable rule. Simultaneous requests under the high vector base show both the priority rule and the vector base. The request patterns that follow are distinct. In one, a normal request is held through a fast handler and then taken on return. In another, a fast entry is nested inside a normal handler and unwound in order. A return is issued from a non-interrupt mode, and a return and a status write collide with an entry edge. A long pseudo-random phase mixes all inputs against the cycle model to reach orderings that the directed steps miss.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_FAST = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_NORM = 5'b10010;
  localparam int BIT_STATE = 5;
  localparam int BIT_FDIS = 6;
  localparam int BIT_IDIS = 7;
  localparam logic [XLEN-1:0] VEC_LOW_BASE = 32'h0000_0000;
  localparam logic [XLEN-1:0] VEC_HIGH_BASE = 32'hFFFF_0000;
  localparam logic [XLEN-1:0] VEC_NORM_OFS = 32'h0000_0018;
  localparam logic [XLEN-1:0] VEC_FAST_OFS = 32'h0000_001C;
  localparam logic [XLEN-1:0] LINK_ADJ = 32'd4;

  typedef struct packed {
    logic takeFast;
    logic takeNorm;
    logic retFast;
    logic retNorm;
    logic wrStatus;
  } excStrobe_t;
endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            fastSync,
  input  logic            normSync,
  input  logic [XLEN-1:0] curStatus,
  input  logic            retReq,
  input  logic            statusWrEn,
  output excStrobe_t      stb
);
  logic fastOk, normOk, anyTake;
  logic [MODE_W-1:0] curMode;

  always_comb begin
    curMode = curStatus[MODE_W-1:0];
    fastOk = fastSync && !curStatus[BIT_FDIS];
    normOk = normSync && !curStatus[BIT_IDIS];
    anyTake = fastOk || normOk;
    stb = '0;
    stb.takeFast = fastOk;
    stb.takeNorm = normOk && !fastOk;
    stb.retFast = !anyTake && retReq && (curMode == MODE_FAST);
    stb.retNorm = !anyTake && retReq && (curMode == MODE_NORM);
    stb.wrStatus = !anyTake && !stb.retFast && !stb.retNorm && statusWrEn;
  end

  // R9: at most one operation per cycle
  p_one_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeFast, stb.takeNorm, stb.retFast, stb.retNorm, stb.wrStatus}));

  // R4: both pending and enabled means no normal entry
  p_fast_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fastSync && !curStatus[BIT_FDIS]) |-> !stb.takeNorm);

  // R3: disable bits block
  p_fdis_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    curStatus[BIT_FDIS] |-> !stb.takeFast);
  p_idis_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    curStatus[BIT_IDIS] |-> !stb.takeNorm);
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_STATUS = 32'h0000_00D3
) (
  input  logic            clk,
  input  logic            rstN,
  input  excStrobe_t      stb,
  input  logic            highVec,
  input  logic [XLEN-1:0] nextPc,
  input  logic [XLEN-1:0] statusWrData,
  output logic [XLEN-1:0] statusQ,
  output logic [XLEN-1:0] pcQ,
  output logic            pcLoadQ,
  output logic [XLEN-1:0] linkFastQ,
  output logic [XLEN-1:0] linkNormQ,
  output logic [XLEN-1:0] savedFastQ,
  output logic [XLEN-1:0] savedNormQ
);
  logic [XLEN-1:0] entryStatus, vecAddr, vecBase, linkNew;
  logic takeAny;

  always_comb begin
    takeAny = stb.takeFast || stb.takeNorm;
    vecBase = highVec ? VEC_HIGH_BASE : VEC_LOW_BASE;
    vecAddr = vecBase | (stb.takeFast ? VEC_FAST_OFS : VEC_NORM_OFS);
    linkNew = nextPc + LINK_ADJ;
    entryStatus = statusQ;
    entryStatus[MODE_W-1:0] = stb.takeFast ? MODE_FAST : MODE_NORM;
    entryStatus[BIT_STATE] = 1'b0;
    entryStatus[BIT_IDIS] = 1'b1;
    if (stb.takeFast) entryStatus[BIT_FDIS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= RESET_STATUS;
      pcQ <= '0;
      pcLoadQ <= 1'b0;
      linkFastQ <= '0;
      linkNormQ <= '0;
      savedFastQ <= '0;
      savedNormQ <= '0;
    end else begin
      pcLoadQ <= takeAny || stb.retFast || stb.retNorm;
      if (takeAny) begin
        statusQ <= entryStatus;
        pcQ <= vecAddr;
        if (stb.takeFast) begin
          savedFastQ <= statusQ;
          linkFastQ <= linkNew;
        end else begin
          savedNormQ <= statusQ;
          linkNormQ <= linkNew;
        end
      end else if (stb.retFast) begin
        statusQ <= savedFastQ;
        pcQ <= linkFastQ - LINK_ADJ;
      end else if (stb.retNorm) begin
        statusQ <= savedNormQ;
        pcQ <= linkNormQ - LINK_ADJ;
      end else if (stb.wrStatus) begin
        statusQ <= statusWrData;
      end
    end
  end

  // R6: entry mode encodings and bit updates
  p_fast_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeFast |=> (statusQ[7:0] == 8'hD1));
  p_norm_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeNorm |=> (statusQ[4:0] == 5'b10010 && statusQ[7] && !statusQ[5]
                      && statusQ[6] == $past(statusQ[6])));
  p_upper_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeFast || stb.takeNorm) |=> (statusQ[31:8] == $past(statusQ[31:8])));
  // R5: link and saved copy
  p_link_fast_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeFast |=> (linkFastQ == $past(nextPc) + 32'd4 && savedFastQ == $past(statusQ)));
  p_link_norm_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeNorm |=> (linkNormQ == $past(nextPc) + 32'd4 && savedNormQ == $past(statusQ)));
  // R7: vector low bits
  p_vec_fast_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeFast |=> (pcQ[15:0] == 16'h001C));
  // R8: return restores
  p_ret_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.retFast |=> (statusQ == $past(savedFastQ) && pcQ == $past(linkFastQ) - 32'd4));
  // R10: load pulse
  p_pcload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeFast || stb.takeNorm || stb.retFast || stb.retNorm) |=> pcLoadQ);
  p_pcstable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pcLoadQ |-> $stable(pcQ));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_STATUS = 32'h0000_00D3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fastReq,
  input  logic        normReq,
  input  logic        highVec,
  input  logic [31:0] nextPc,
  input  logic        retReq,
  input  logic        statusWrEn,
  input  logic [31:0] statusWrData,
  output logic [31:0] statusOut,
  output logic [31:0] pcOut,
  output logic        pcLoad,
  output logic [31:0] linkFast,
  output logic [31:0] linkNorm,
  output logic [31:0] savedFast,
  output logic [31:0] savedNorm
);
  logic [1:0] reqSync;
  excStrobe_t stb;

  exc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({fastReq, normReq}), .syncOut(reqSync)
  );

  exc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fastSync(reqSync[1]), .normSync(reqSync[0]),
    .curStatus(statusOut), .retReq(retReq), .statusWrEn(statusWrEn), .stb(stb)
  );

  exc_datapath #(.RESET_STATUS(RESET_STATUS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .highVec(highVec), .nextPc(nextPc),
    .statusWrData(statusWrData), .statusQ(statusOut), .pcQ(pcOut),
    .pcLoadQ(pcLoad), .linkFastQ(linkFast), .linkNormQ(linkNorm),
    .savedFastQ(savedFast), .savedNormQ(savedNorm)
  );
endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rstN = 0;
  logic fastReq = 0, normReq = 0, highVec = 0, retReq = 0, statusWrEn = 0;
  logic [31:0] nextPc = 0, statusWrData = 0;
  logic [31:0] statusOut, pcOut, linkFast, linkNorm, savedFast, savedNorm;
  logic pcLoad;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  exc_entry_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit fastQ[$], normQ[$];
  logic [31:0] mStatus, mPc, mLf, mLn, mSf, mSn;
  bit mLoad;

  task automatic modelReset();
    fastQ = '{0, 0}; normQ = '{0, 0};
    mStatus = 32'h0000_00D3; mPc = 0; mLoad = 0;
    mLf = 0; mLn = 0; mSf = 0; mSn = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit f, n, tf, tn;
      logic [31:0] ns;
      f = fastQ.pop_front(); n = normQ.pop_front();
      fastQ.push_back(fastReq); normQ.push_back(normReq);
      tf = f && (mStatus[6] == 0);
      tn = n && (mStatus[7] == 0) && !tf;
      mLoad = 0;
      if (tf || tn) begin
        ns = mStatus;
        ns[4:0] = tf ? 5'b10001 : 5'b10010;
        ns[5] = 0; ns[7] = 1;
        if (tf) ns[6] = 1;
        if (tf) begin mSf = mStatus; mLf = nextPc + 4; end
        else begin mSn = mStatus; mLn = nextPc + 4; end
        mPc = (highVec ? 32'hFFFF0000 : 0) + (tf ? 32'h1C : 32'h18);
        mStatus = ns; mLoad = 1;
      end else if (retReq && mStatus[4:0] == 5'b10001) begin
        mPc = mLf - 4; mStatus = mSf; mLoad = 1;
      end else if (retReq && mStatus[4:0] == 5'b10010) begin
        mPc = mLn - 4; mStatus = mSn; mLoad = 1;
      end else if (statusWrEn) mStatus = statusWrData;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    chk("R6", "statusOut", statusOut, mStatus);
    chk("R7", "pcOut", pcOut, mPc);
    chk("R10", "pcLoad", {31'd0, pcLoad}, {31'd0, mLoad});
    chk("R5", "linkFast", linkFast, mLf);
    chk("R5", "linkNorm", linkNorm, mLn);
    chk("R5", "savedFast", savedFast, mSf);
    chk("R5", "savedNorm", savedNorm, mSn);
  end

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wrStatus(logic [31:0] v);
    statusWrEn = 1; statusWrData = v; step(); statusWrEn = 0;
  endtask

  task automatic doRet();
    retReq = 1; step(); retReq = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    step(2);
    // R1 reset state
    chk("R1", "statusOut", statusOut, 32'h0000_00D3);
    chk("R1", "pcOut", pcOut, 0);
    chk("R1", "pcLoad", {31'd0, pcLoad}, 0);
    chk("R1", "linkFast", linkFast, 0);
    rstN = 1; step();

    // R3: both disabled by reset status
    fastReq = 1; normReq = 1; step(5);
    chk("R3", "pc unchanged both masked", pcOut, 0);
    fastReq = 0; normReq = 0; step(3);
    wrStatus(32'h0000_0053);                 // F set, I clear, R11
    chk("R11", "status write", statusOut, 32'h0000_0053);
    fastReq = 1; step(5);
    chk("R3", "fast masked by bit6", statusOut, 32'h0000_0053);
    fastReq = 0; step(3);

    // R2/R6 normal entry: bit5 set, bit6 clear beforehand
    wrStatus(32'h1234_5633);
    nextPc = 32'h0000_1000;
    normReq = 1;
    step(2);
    chk("R2", "no entry before third edge", {31'd0, pcLoad}, 0);
    step();
    chk("R2", "entry at third edge", {31'd0, pcLoad}, 1);
    chk("R6", "normal entry status", statusOut, 32'h1234_5692);
    chk("R7", "normal low vector", pcOut, 32'h0000_0018);
    chk("R5", "normal link", linkNorm, 32'h0000_1004);
    chk("R5", "normal saved", savedNorm, 32'h1234_5633);
    normReq = 0; step(3);
    doRet();
    chk("R8", "return pc", pcOut, 32'h0000_1000);
    chk("R8", "return status", statusOut, 32'h1234_5633);
    step(2);

    // R4/R7 both at once, high vectors
    highVec = 1; nextPc = 32'h0000_2000;
    fastReq = 1; normReq = 1; step(3);
    chk("R4", "fast taken", statusOut, 32'h1234_56D1);
    chk("R7", "fast high vector", pcOut, 32'hFFFF_001C);
    fastReq = 0; step(6);
    chk("R4", "normal blocked while I set", pcOut, 32'hFFFF_001C);
    nextPc = 32'h0000_3000;
    doRet();                                  // normal still held
    chk("R8", "fast return pc", pcOut, 32'h0000_2000);
    step(1); normReq = 0; step(3);
    chk("R7", "normal high vector", pcOut, 32'hFFFF_0018);
    doRet(); step(2);

    // nested: fast inside normal handler
    highVec = 0; nextPc = 32'h0000_4000;
    normReq = 1; step(1); normReq = 0; step(4);
    nextPc = 32'h0000_5000;
    fastReq = 1; step(1); fastReq = 0; step(4);
    chk("R5", "nested saved fast is normal mode", savedFast[4:0], 5'b10010);
    doRet();
    chk("R8", "back in normal mode", statusOut[4:0], 5'b10010);
    doRet();
    chk("R8", "back to original", statusOut, 32'h1234_5633);
    step(2);

    // R8 return from other mode ignored
    wrStatus(32'h0000_00D3);
    doRet();
    chk("R8", "return ignored pcLoad", {31'd0, pcLoad}, 0);
    chk("R8", "return ignored status", statusOut, 32'h0000_00D3);

    // R9 collision: return and write on the entry edge
    wrStatus(32'h0000_0013);
    nextPc = 32'h0000_6000;
    normReq = 1; step(2);
    retReq = 1; statusWrEn = 1; statusWrData = 32'hDEAD_0000; step();
    retReq = 0; statusWrEn = 0; normReq = 0;
    chk("R9", "entry wins", statusOut, 32'h0000_0092);
    step(3);
    retReq = 1; statusWrEn = 1; statusWrData = 32'hBEEF_0000; step();
    retReq = 0; statusWrEn = 0;
    chk("R9", "return wins over write", statusOut, 32'h0000_0013);
    step(2);

    // pseudo-random mixing
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fastReq = lfsr[0] & lfsr[3];
      normReq = lfsr[1];
      highVec = lfsr[2];
      retReq = lfsr[4] & lfsr[5];
      statusWrEn = (lfsr[6:9] == 4'hF);
      statusWrData = {lfsr, lfsr[7:0], lfsr[11:10], 1'b1, lfsr[12], 4'h3};
      nextPc = {lfsr, lfsr} & 32'hFFFF_FFFC;
      step();
    end
    fastReq = 0; normReq = 0; retReq = 0; statusWrEn = 0;
    step(4);
    finishRun();
  end
endmodule